// File: doc/BRIEF.md
# Write-Intensity History Table

This block keeps a short, fully associative record of which cache line addresses receive write hits most often. Every write hit is presented with its line address. An address already in the table has its counter raised. A new address takes a free slot, or the slot that was touched least recently when all slots are in use. A timer inside the block lowers every counter at a fixed interval, so addresses that stop being written drop out of the table.

When a counter reaches a configured limit, the block raises a one-cycle promotion request that carries the address. The cache controller uses this request to move the line into its fast-write region. The counter of that entry then restarts from zero, so the request is not repeated. A separate combinational lookup port reports whether a given address is currently held. The same block can record read intensity if it is fed with read-hit strobes instead of write hits.

Top module: `wr_heat_table`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the table is empty. `lkp_hit` is 0 for every address and `promo_vld` is 0.
- R2: A write to an address that is not held stores it with count 1 in the lowest-numbered empty slot. From the next cycle, `lkp_hit` is 1 when `lkp_addr` equals that address.
- R3: A write to an address that is held raises that entry's count by one, saturating at 2^CNT_W-1. The entry becomes the most recently touched.
- R4: A write to an address that is not held, while every slot is occupied, replaces the entry touched least recently. Both inserts and matching writes count as touches.
- R5: Every DECAY_PERIOD cycles after reset, every count drops by one. An entry whose count was 1 or 0 at that moment becomes empty.
- R6: When a write and a decay step fall in the same cycle, the decay is applied first and the increment second. The matching of the address uses the table as it stood before the decay, so a matching entry that decays to zero in that cycle returns with count 1.
- R7: When a write brings an entry's count to LIMIT or above, `promo_vld` is 1 in the following cycle with `promo_addr` equal to that address. The entry stays held with count 0.
- R8: The lookup port has no effect on the table. Without a write or a decay step, the set of held addresses does not change.
- R9: At most one address enters the table per cycle, and exactly one slot is the least recently touched at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_vld | input | 1 | Write-hit strobe |
| wr_addr | input | ADDR_W | Line address of the write hit |
| lkp_addr | input | ADDR_W | Address to look up |
| lkp_hit | output | 1 | Lookup address is held (combinational) |
| promo_vld | output | 1 | Promotion request, one cycle |
| promo_addr | output | ADDR_W | Address to promote |

## Verification
The bench builds the table with 4 entries, 8-bit addresses, 3-bit counters, a limit of 5 and a decay period of 40 cycles. With these values, full-table replacement, promotions and ageing-out all occur within a few dozen cycles. A random stream over six addresses then makes writes coincide with decay steps many times. A long idle tail at the end drains the table through decay alone.

// File: rtl/wr_heat_table.sv
module wr_heat_table #(
  parameter int ENTRIES      = 16,
  parameter int ADDR_W       = 32,
  parameter int CNT_W        = 4,
  parameter int LIMIT        = 11,
  parameter int DECAY_PERIOD = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_vld,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ADDR_W-1:0] lkp_addr,
  output logic              lkp_hit,
  output logic              promo_vld,
  output logic [ADDR_W-1:0] promo_addr
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int TMR_W = (DECAY_PERIOD > 1) ? $clog2(DECAY_PERIOD) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(LIMIT);

  logic [ENTRIES-1:0] valid_q;
  logic [ADDR_W-1:0]  addr_q [ENTRIES];
  logic [CNT_W-1:0]   cnt_q  [ENTRIES];
  logic [IDX_W-1:0]   rank_q [ENTRIES];
  logic [TMR_W-1:0]   tmr_q;

  logic [ENTRIES-1:0] hit_vec, lkp_vec, lru_vec;
  logic [IDX_W-1:0]   hit_idx, free_idx, lru_idx, tgt;
  logic               hit_any, any_free, tick, fire;
  logic [CNT_W-1:0]   cur_cnt, dec_cnt, base_cnt, new_cnt;

  assign tick = (tmr_q == TMR_W'(DECAY_PERIOD - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= tick ? '0 : tmr_q + 1'b1;

  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    lru_idx  = '0;
    any_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      hit_vec[i] = valid_q[i] && (addr_q[i] == wr_addr);
      lkp_vec[i] = valid_q[i] && (addr_q[i] == lkp_addr);
      lru_vec[i] = (rank_q[i] == IDX_W'(ENTRIES - 1));
      if (hit_vec[i]) hit_idx = IDX_W'(i);
      if (lru_vec[i]) lru_idx = IDX_W'(i);
      if (!valid_q[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end

  assign hit_any  = |hit_vec;
  assign lkp_hit  = |lkp_vec;
  assign tgt      = hit_any ? hit_idx : (any_free ? free_idx : lru_idx);
  assign cur_cnt  = cnt_q[tgt];
  assign dec_cnt  = (cur_cnt > 1) ? cur_cnt - 1'b1 : '0;
  assign base_cnt = !hit_any ? '0 : (tick ? dec_cnt : cur_cnt);
  assign new_cnt  = (base_cnt == CNT_MAX) ? base_cnt : base_cnt + 1'b1;
  assign fire     = wr_vld && (new_cnt >= CNT_LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q    <= '0;
      promo_vld  <= 1'b0;
      promo_addr <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        addr_q[i] <= '0;
        cnt_q[i]  <= '0;
        rank_q[i] <= IDX_W'(i);
      end
    end else begin
      promo_vld <= fire;
      if (fire) promo_addr <= wr_addr;
      for (int i = 0; i < ENTRIES; i++) begin
        if (tick) begin
          if (cnt_q[i] > 1) cnt_q[i] <= cnt_q[i] - 1'b1;
          else begin
            cnt_q[i]   <= '0;
            valid_q[i] <= 1'b0;
          end
        end
        if (wr_vld) begin
          if (IDX_W'(i) == tgt) begin
            valid_q[i] <= 1'b1;
            addr_q[i]  <= wr_addr;
            cnt_q[i]   <= fire ? '0 : new_cnt;
            rank_q[i]  <= '0;
          end else if (rank_q[i] < rank_q[tgt]) begin
            rank_q[i]  <= rank_q[i] + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/wr_heat_table_chk.sv
module wr_heat_table_chk #(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_vld,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [ADDR_W-1:0]  lkp_addr,
  input logic               lkp_hit,
  input logic               promo_vld,
  input logic [ADDR_W-1:0]  promo_addr,
  input logic               tick,
  input logic [ENTRIES-1:0] valid_q,
  input logic [ENTRIES-1:0] lru_vec
);
  AST_WRITE_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_vld ##1 (lkp_addr == $past(wr_addr)) |-> lkp_hit); // R2
  AST_LRU_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lru_vec) == 1); // R4
  AST_TICK_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_vld) |=> $countones(valid_q) <= $past($countones(valid_q))); // R5
  AST_PROMO_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    promo_vld |-> ($past(wr_vld) && promo_addr == $past(wr_addr))); // R7
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_vld && !tick) |=> $stable(valid_q)); // R8
  AST_SINGLE_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(valid_q) <= $past($countones(valid_q)) + 1); // R9
endmodule

bind wr_heat_table wr_heat_table_chk #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_vld(wr_vld), .wr_addr(wr_addr),
  .lkp_addr(lkp_addr), .lkp_hit(lkp_hit), .promo_vld(promo_vld),
  .promo_addr(promo_addr), .tick(tick), .valid_q(valid_q), .lru_vec(lru_vec)
);

// File: tb/wr_heat_table_tb_top.sv
module wr_heat_table_tb_top;
  localparam int N  = 4;
  localparam int AW = 8;
  localparam int CW = 3;
  localparam int LIM = 5;
  localparam int DP = 40;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_vld = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [AW-1:0] lkp_addr = '0;
  logic lkp_hit, promo_vld;
  logic [AW-1:0] promo_addr;

  always #10 clk = ~clk;

  wr_heat_table #(.ENTRIES(N), .ADDR_W(AW), .CNT_W(CW), .LIMIT(LIM), .DECAY_PERIOD(DP)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_vld(wr_vld), .wr_addr(wr_addr), .lkp_addr(lkp_addr),
    .lkp_hit(lkp_hit), .promo_vld(promo_vld), .promo_addr(promo_addr));

  int checks = 0;
  int fails = 0;

  // reference model: per-slot address, count, presence and last-touch time
  int m_addr [N];
  int m_cnt  [N];
  int m_ts   [N];
  bit m_val  [N];
  int now, cyc, mi, fi, k, c;
  bit mtick, exp_promo;
  int exp_paddr;
  string tag, lk_tag;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < N; j++) begin
        m_val[j] = 0; m_cnt[j] = 0; m_addr[j] = 0; m_ts[j] = 0;
      end
      now = 0; cyc = 0; exp_promo = 0; tag = "R1"; lk_tag = "R1";
    end else begin
      now++;
      mtick = (cyc == DP - 1);
      cyc = mtick ? 0 : cyc + 1;
      exp_promo = 0;
      tag = "R8";
      mi = -1; fi = -1;
      for (int j = N - 1; j >= 0; j--) begin
        if (m_val[j] && m_addr[j] == int'(wr_addr)) mi = j;
        if (!m_val[j]) fi = j;
      end
      if (mtick) begin
        tag = "R5";
        for (int j = 0; j < N; j++)
          if (m_cnt[j] > 1) m_cnt[j]--;
          else begin m_cnt[j] = 0; m_val[j] = 0; end
      end
      if (wr_vld) begin
        if (mi >= 0) begin k = mi; c = m_cnt[k] + 1; tag = mtick ? "R6" : "R3"; end
        else if (fi >= 0) begin k = fi; c = 1; tag = "R2"; end
        else begin
          k = 0;
          for (int j = 1; j < N; j++) if (m_ts[j] < m_ts[k]) k = j;
          c = 1; tag = "R4";
        end
        if (c > CMAX) c = CMAX;
        m_val[k] = 1; m_addr[k] = int'(wr_addr); m_ts[k] = now;
        if (c >= LIM) begin
          exp_promo = 1; exp_paddr = int'(wr_addr); m_cnt[k] = 0; tag = "R7";
        end else m_cnt[k] = c;
      end
      lk_tag = tag;
    end
  end

  function automatic int model_lkp(input int a);
    for (int j = 0; j < N; j++) if (m_val[j] && m_addr[j] == a) return 1;
    return 0;
  endfunction

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      check({tag, " promo_vld"}, int'(promo_vld), int'(exp_promo));
      if (exp_promo) check("R7 promo_addr", int'(promo_addr), exp_paddr);
      check({lk_tag, " lkp_hit"}, int'(lkp_hit), model_lkp(int'(lkp_addr)));
    end
  end

  task automatic step(input bit w, input int a, input int l);
    @(negedge clk);
    wr_vld = w; wr_addr = AW'(a); lkp_addr = AW'(l);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed = 32'h1234;
    repeat (3) @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      lkp_addr = AW'(a * 16); #1;
      check("R1 lkp_hit in reset", int'(lkp_hit), 0);
      check("R1 promo_vld in reset", int'(promo_vld), 0);
    end
    @(negedge clk); rst_n = 1'b1;
    // R2 insert, R3 repeat hits, R7 promotion on the fifth write
    step(1, 'h10, 'h10);
    repeat (4) step(1, 'h10, 'h10);
    // R8 lookups only
    for (int a = 0; a < 8; a++) step(0, 0, 'h10 + a);
    // R4 fill and evict least recently touched
    step(1, 'h21, 'h10); step(1, 'h22, 'h21); step(1, 'h23, 'h22);
    step(1, 'h21, 'h23); step(1, 'h24, 'h10); step(0, 0, 'h10);
    step(0, 0, 'h24);
    // random traffic: covers R5 and R6 coincidences
    for (int n = 0; n < 3000; n++) begin
      seed = seed * 1103515245 + 12345;
      step(seed[20], 'h30 + int'(seed[27:24] % 6), 'h30 + int'(seed[19:16] % 6));
    end
    // idle drain, R5
    for (int n = 0; n < 400; n++) step(0, 0, 'h30 + (n % 6));
    step(0, 0, 'h30);
    @(negedge clk); #2;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule